// File: doc/BRIEF.md
# Cache Invalidation Sequencer

This block carries out invalidate commands against the directory of a two-set cache with 1024 line indices per set. Each directory entry holds a page key, a user-line flag, a temporary-data flag and four per-word residency bits. An entry is invalidated by clearing its residency bits. Its tag is left alone, so the next reference to that line misses.

A command arrives over a valid/ready handshake. It carries one of four opcodes, a byte address and the privilege mode of the requester. The sequencer owns the directory port until it finishes. For every entry it visits, it spends one cycle reading the entry and one cycle deciding whether the entry qualifies. In the deciding cycle it writes back the cleared entry when the entry qualifies. At the end it raises a one-cycle done pulse.

A line command visits the two entries at one index. The page, whole-cache and temporary-data commands walk the entire directory. Except for the line command, each command is narrowed by the requester's mode. The page command is also narrowed by the page key, and the temporary-data command by the temporary-data flag.

Top module: `inv_seq`

## Requirements
- R1: A directory entry is 24 bits, with the residency bits in [3:0], the temporary-data flag in [4], the user-line flag in [5] and the page key in [23:6]. Every write sends back the entry just read, with residency bits [3:0] zero and bits [23:4] unchanged.
- R2: Opcode 0 (line) uses address bits [13:4] as the index and address bits [31:14] as the key. It clears the entries at that index, in either set, whose key matches. The mode is not applied.
- R3: Opcode 1 (page) clears every entry in both sets whose key equals address bits [31:14] and which passes the mode filter.
- R4: Opcode 2 (whole cache) with cmd_user=0 (supervisor) clears every entry. With cmd_user=1 it clears only entries whose user-line flag is 1. This mode filter also applies to opcodes 1 and 3.
- R5: Opcode 3 (temporary data) clears only entries whose temporary-data flag is 1 and which pass the mode filter.
- R6: No write is issued to an entry that fails its command's filter, or whose residency bits are already all zero. Such entries keep their contents.
- R7: A walk visits index 0 to 1023 in ascending order, with set 0 before set 1 at each index. Each entry takes a read cycle with dir_rd_en high, with data returned on dir_rdata in the next cycle, followed by a decision cycle. From acceptance, done rises in cycle 2·E+1 for E entries visited and stays high for one cycle. busy is high from the cycle after acceptance through the done cycle.
- R8: A command is accepted when cmd_valid and cmd_ready are both high. cmd_ready is high only while idle, so commands offered during a walk are refused and have no effect.
- R9: After reset, cmd_ready is 1 and busy, done, dir_rd_en and dir_wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to accept |
| cmd_op | input | 2 | 0 line, 1 page, 2 whole cache, 3 temporary data |
| cmd_addr | input | 32 | Byte address selecting line index and page key |
| cmd_user | input | 1 | 1 when the requester runs in user mode |
| busy | output | 1 | Walk in progress, directory port owned |
| done | output | 1 | One-cycle completion pulse |
| dir_rd_en | output | 1 | Directory read strobe |
| dir_wr_en | output | 1 | Directory write strobe |
| dir_idx | output | 10 | Directory line index |
| dir_set | output | 1 | Directory set select |
| dir_wdata | output | 24 | Entry written back |
| dir_rdata | input | 24 | Entry read, valid the cycle after dir_rd_en |

## Verification
The bench targets four kinds of fault.
- A supervisor entry whose key matches a user-mode line command must still be cleared. A design that applied the mode filter to line commands would leave that entry resident.
- A page command in user mode runs against a directory that mixes keys and both privilege flags. A design that ignored either the key or the mode would write entries that must survive.
- A whole-cache command is offered in the middle of another walk. A design that accepted it would clear entries the reference model keeps.
- The walk must visit the last index and must take exactly two cycles per entry. Off-by-one counters and early or double done pulses show up as a different completion cycle or as missing writes at index 1023.

// File: rtl/inv_pkg.sv
package inv_pkg;
   parameter int KEY_W = 18;
   parameter int RES_W = 4;

   typedef struct packed {
      logic [KEY_W-1:0] key;
      logic             usr;
      logic             tmp;
      logic [RES_W-1:0] res;
   } dir_ent_t;

   localparam int ENT_W = $bits(dir_ent_t);

   typedef enum logic [1:0] {
      OP_LINE = 2'd0,
      OP_PAGE = 2'd1,
      OP_ALL  = 2'd2,
      OP_TMP  = 2'd3
   } inv_op_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RD   = 2'd1,
      S_CK   = 2'd2,
      S_DONE = 2'd3
   } seq_st_e;
endpackage

// File: rtl/inv_cmd_reg.sv
module inv_cmd_reg
   import inv_pkg::*;
#(
   parameter int IDX_W  = 10,
   parameter int OFS_W  = 4,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  inv_op_e           op_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              user_in,
   output inv_op_e           op_q,
   output logic [KEY_W-1:0]  key_q,
   output logic              user_q
);
   logic unused_low;
   assign unused_low = ^addr_in[OFS_W+IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_LINE;
         key_q  <= '0;
         user_q <= 1'b0;
      end else if (load) begin
         op_q   <= op_in;
         key_q  <= addr_in[ADDR_W-1 -: KEY_W];
         user_q <= user_in;
      end
   end
endmodule

// File: rtl/inv_walker.sv
module inv_walker #(
   parameter int IDX_W    = 10,
   parameter int NUM_SETS = 2,
   localparam int SET_W   = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             single,
   input  logic [IDX_W-1:0] load_idx,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic [SET_W-1:0] set,
   output logic             last
);
   localparam logic [SET_W-1:0] SET_TOP = SET_W'(NUM_SETS - 1);
   localparam logic [IDX_W-1:0] IDX_TOP = '1;

   logic single_q;
   logic set_wrap;

   assign set_wrap = (set == SET_TOP);
   assign last     = set_wrap && (single_q || idx == IDX_TOP);

   logic [SET_W-1:0] set_nx;
   generate
      if ((NUM_SETS & (NUM_SETS - 1)) == 0) begin : g_pow2
         assign set_nx = set + 1'b1;
      end else begin : g_cmp
         assign set_nx = set_wrap ? '0 : set + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx      <= '0;
         set      <= '0;
         single_q <= 1'b0;
      end else if (load) begin
         idx      <= single ? load_idx : '0;
         set      <= '0;
         single_q <= single;
      end else if (step) begin
         set <= set_nx;
         if (set_wrap && !single_q) idx <= idx + 1'b1;
      end
   end

   AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) step && !load && set_wrap && !last |=> idx == $past(idx) + 1'b1); // R7
   AST_SET_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) step && !load && !set_wrap |=> idx == $past(idx)); // R7
endmodule

// File: rtl/inv_filter.sv
module inv_filter
   import inv_pkg::*;
#(
   parameter bit SKIP_EMPTY = 1'b1
) (
   input  inv_op_e          op,
   input  logic             user,
   input  logic [KEY_W-1:0] key,
   input  dir_ent_t         ent,
   output logic             qual,
   output dir_ent_t         wdata
);
   logic mode_ok;
   logic key_ok;
   logic match;

   assign mode_ok = !user || ent.usr;
   assign key_ok  = (ent.key == key);

   always_comb begin
      unique case (op)
         OP_LINE: match = key_ok;
         OP_PAGE: match = key_ok && mode_ok;
         OP_ALL:  match = mode_ok;
         default: match = ent.tmp && mode_ok;
      endcase
   end

   generate
      if (SKIP_EMPTY) begin : g_skip
         assign qual = match && (|ent.res);
      end else begin : g_always
         assign qual = match;
      end
   endgenerate

   always_comb begin
      wdata     = ent;
      wdata.res = '0;
   end
endmodule

// File: rtl/inv_seq.sv
module inv_seq
   import inv_pkg::*;
#(
   parameter int IDX_W      = 10,
   parameter int NUM_SETS   = 2,
   parameter int OFS_W      = 4,
   parameter int ADDR_W     = 32,
   parameter bit SKIP_EMPTY = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   output logic                        cmd_ready,
   input  logic [1:0]                  cmd_op,
   input  logic [ADDR_W-1:0]           cmd_addr,
   input  logic                        cmd_user,
   output logic                        busy,
   output logic                        done,
   output logic                        dir_rd_en,
   output logic                        dir_wr_en,
   output logic [IDX_W-1:0]            dir_idx,
   output logic [$clog2(NUM_SETS)-1:0] dir_set,
   output logic [ENT_W-1:0]            dir_wdata,
   input  logic [ENT_W-1:0]            dir_rdata
);
   generate
      if (ADDR_W != KEY_W + IDX_W + OFS_W) begin : g_bad_addr
         $error("inv_seq: ADDR_W must equal key, index and offset widths combined");
      end
      if (NUM_SETS < 2) begin : g_bad_sets
         $error("inv_seq: NUM_SETS must be at least 2");
      end
      if (IDX_W < 1 || OFS_W < 0) begin : g_bad_idx
         $error("inv_seq: IDX_W must be positive and OFS_W non-negative");
      end
   endgenerate

   seq_st_e   st;
   inv_op_e   op_in;
   inv_op_e   op_q;
   logic [KEY_W-1:0] key_q;
   logic      user_q;
   logic      accept;
   logic      last;
   logic      qual;
   dir_ent_t  rd_ent;
   dir_ent_t  wr_ent;

   assign op_in     = inv_op_e'(cmd_op);
   assign cmd_ready = (st == S_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign busy      = (st != S_IDLE);
   assign done      = (st == S_DONE);
   assign dir_rd_en = (st == S_RD);
   assign dir_wr_en = (st == S_CK) && qual;
   assign rd_ent    = dir_ent_t'(dir_rdata);
   assign dir_wdata = wr_ent;

   inv_cmd_reg #(.IDX_W(IDX_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .op_in   (op_in),
      .addr_in (cmd_addr),
      .user_in (cmd_user),
      .op_q    (op_q),
      .key_q   (key_q),
      .user_q  (user_q)
   );

   inv_walker #(.IDX_W(IDX_W), .NUM_SETS(NUM_SETS)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .single   (op_in == OP_LINE),
      .load_idx (cmd_addr[OFS_W +: IDX_W]),
      .step     (st == S_CK),
      .idx      (dir_idx),
      .set      (dir_set),
      .last     (last)
   );

   inv_filter #(.SKIP_EMPTY(SKIP_EMPTY)) u_filt (
      .op    (op_q),
      .user  (user_q),
      .key   (key_q),
      .ent   (rd_ent),
      .qual  (qual),
      .wdata (wr_ent)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_IDLE;
      end else begin
         unique case (st)
            S_IDLE:  if (accept) st <= S_RD;
            S_RD:    st <= S_CK;
            S_CK:    st <= last ? S_DONE : S_RD;
            default: st <= S_IDLE;
         endcase
      end
   end

   AST_RD_WR_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(dir_rd_en && dir_wr_en)); // R7
   AST_RD_THEN_CK:    assert property (@(posedge clk) disable iff (!rst_n) dir_rd_en |=> !dir_rd_en && busy); // R7
   AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done && !busy); // R7
   AST_ACCEPT_START:  assert property (@(posedge clk) disable iff (!rst_n) cmd_valid && cmd_ready |=> dir_rd_en); // R8
   AST_WR_CLEARS_RES: assert property (@(posedge clk) disable iff (!rst_n) dir_wr_en |-> dir_wdata[RES_W-1:0] == '0); // R1
   AST_WR_KEEPS_TAG:  assert property (@(posedge clk) disable iff (!rst_n) dir_wr_en |-> dir_wdata[ENT_W-1:RES_W] == dir_rdata[ENT_W-1:RES_W]); // R1
   AST_KEY_MATCH:     assert property (@(posedge clk) disable iff (!rst_n) dir_wr_en && (op_q == OP_LINE || op_q == OP_PAGE) |-> rd_ent.key == key_q); // R3
   AST_USER_ONLY:     assert property (@(posedge clk) disable iff (!rst_n) dir_wr_en && user_q && op_q != OP_LINE |-> rd_ent.usr); // R4
   AST_TMP_ONLY:      assert property (@(posedge clk) disable iff (!rst_n) dir_wr_en && op_q == OP_TMP |-> rd_ent.tmp); // R5

   generate
      if (SKIP_EMPTY) begin : g_chk_skip
         AST_NO_EMPTY_WR: assert property (@(posedge clk) disable iff (!rst_n) dir_wr_en |-> |dir_rdata[RES_W-1:0]); // R6
      end
   endgenerate
endmodule

// File: tb/tb_inv_seq.sv
`timescale 1ns/1ps
module tb_inv_seq;
   import inv_pkg::*;

   localparam int NIDX = 1024;
   localparam logic [17:0] K0 = 18'h00123;
   localparam logic [17:0] K1 = 18'h2ABCD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd0;
   logic [31:0] cmd_addr = '0;
   logic        cmd_user = 1'b0;
   logic        busy, done, dir_rd_en, dir_wr_en;
   logic [9:0]  dir_idx;
   logic [0:0]  dir_set;
   logic [23:0] dir_wdata;
   logic [23:0] dir_rdata = '0;

   always #2 clk = ~clk;

   inv_seq dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_user(cmd_user),
      .busy(busy), .done(done), .dir_rd_en(dir_rd_en), .dir_wr_en(dir_wr_en),
      .dir_idx(dir_idx), .dir_set(dir_set), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata)
   );

   dir_ent_t mem     [0:2*NIDX-1];
   dir_ent_t ref_mem [0:2*NIDX-1];

   always @(posedge clk) begin
      if (dir_wr_en) mem[{dir_set, dir_idx}] <= dir_wdata;
      if (dir_rd_en) dir_rdata <= mem[{dir_set, dir_idx}];
   end

   typedef struct packed {
      logic     s;
      logic [9:0] i;
      dir_ent_t e;
   } wr_item_t;

   wr_item_t   exp_wr[$];
   logic [10:0] exp_rd[$];
   int chk = 0;
   int bad = 0;
   string cur_tag = "R7";

   task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      chk++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected reads and writes as the design issues them
   always @(negedge clk) begin
      if (rst_n && dir_rd_en) begin
         if (exp_rd.size() == 0) check(1'b0, "R7", "unexpected read", {dir_set, dir_idx}, 0);
         else begin
            logic [10:0] er;
            er = exp_rd.pop_front();
            check({dir_set, dir_idx} == er, "R7", "read order", {dir_set, dir_idx}, er);
         end
      end
      if (rst_n && dir_wr_en) begin
         if (exp_wr.size() == 0) check(1'b0, "R6", "unexpected write", {dir_set, dir_idx, dir_wdata}, 0);
         else begin
            wr_item_t ew;
            ew = exp_wr.pop_front();
            check({dir_set, dir_idx, dir_wdata} == ew, cur_tag, "write (R1 value)",
                  {dir_set, dir_idx, dir_wdata}, ew);
         end
      end
   end

   function automatic bit qualifies(logic [1:0] op, logic user, logic [17:0] k, dir_ent_t e);
      bit mode_ok;
      mode_ok = !user || e.usr;
      if (e.res == 0) return 1'b0;
      case (op)
         2'd0:    return e.key == k;
         2'd1:    return (e.key == k) && mode_ok;
         2'd2:    return mode_ok;
         default: return e.tmp && mode_ok;
      endcase
   endfunction

   task automatic fill(input logic [31:0] seed);
      logic [31:0] s;
      s = seed;
      for (int i = 0; i < 2*NIDX; i++) begin
         dir_ent_t e;
         s = s * 32'd1103515245 + 32'd12345;
         case (s[17:16])
            2'd0:    e.key = K0;
            2'd1:    e.key = K1;
            default: e.key = {8'h3C, s[13:4]};
         endcase
         e.usr = s[20];
         e.tmp = s[22];
         e.res = s[27:24];
         mem[i] = e;
         ref_mem[i] = e;
      end
   endtask

   task automatic put(input int s, input int i, input dir_ent_t e);
      mem[s*NIDX+i] = e;
      ref_mem[s*NIDX+i] = e;
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [31:0] addr, input logic user,
                          input bit poke, input string tag);
      int lo, hi, nent, n, diff;
      logic [17:0] k;
      k = addr[31:14];
      lo = (op == 2'd0) ? int'(addr[13:4]) : 0;
      hi = (op == 2'd0) ? int'(addr[13:4]) : NIDX-1;
      nent = 0;
      cur_tag = tag;
      for (int i = lo; i <= hi; i++) begin
         for (int s = 0; s < 2; s++) begin
            dir_ent_t e;
            exp_rd.push_back({s[0], i[9:0]});
            e = ref_mem[s*NIDX+i];
            if (qualifies(op, user, k, e)) begin
               e.res = '0;
               ref_mem[s*NIDX+i] = e;
               exp_wr.push_back({s[0], i[9:0], e});
            end
            nent++;
         end
      end
      @(negedge clk);
      cmd_op = op; cmd_addr = addr; cmd_user = user; cmd_valid = 1'b1;
      @(posedge clk);
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            cmd_valid = 1'b0;
            check(busy == 1'b1, "R7", "busy after accept", busy, 1);
         end
         if (poke && n == 10) begin
            cmd_op = 2'd2; cmd_user = 1'b0; cmd_valid = 1'b1;
         end
         if (poke && n == 12) check(cmd_ready == 1'b0, "R8", "ready while busy", cmd_ready, 0);
         if (poke && n == 19) cmd_valid = 1'b0;
         if (done || n > 5000) break;
      end
      check(n == 2*nent+1, "R7", "done cycle", n, 2*nent+1);
      check(exp_wr.size() == 0 && exp_rd.size() == 0, tag, "missing accesses", exp_wr.size(), 0);
      @(negedge clk);
      check(!done && !busy, "R7", "single done pulse", {done, busy}, 0);
      diff = 0;
      for (int i = 0; i < 2*NIDX; i++) if (mem[i] != ref_mem[i]) diff++;
      check(diff == 0, (poke ? "R8" : "R6"), {tag, " directory contents"}, diff, 0);
      exp_wr.delete();
      exp_rd.delete();
   endtask

   initial begin
      #(4*150000);
      chk++;
      bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", chk - bad, chk);
      $finish;
   end

   initial begin
      fill(32'h1234_5678);
      repeat (4) @(negedge clk);
      check(cmd_ready && !busy && !done && !dir_rd_en && !dir_wr_en, "R9", "reset outputs",
            {cmd_ready, busy, done, dir_rd_en, dir_wr_en}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready && !busy && !done, "R9", "idle after reset", {cmd_ready, busy, done}, 3'b100);

      // R2: supervisor entry with matching key cleared by a user-mode line command
      put(1, 5, '{key: K0, usr: 1'b0, tmp: 1'b0, res: 4'hF});
      put(0, 5, '{key: K1, usr: 1'b1, tmp: 1'b1, res: 4'hF});
      run_cmd(2'd0, {K0, 10'd5, 4'h8}, 1'b1, 1'b0, "R2");
      check(mem[NIDX+5].res == 0 && mem[5].res == 4'hF, "R2", "line hit set 1 only",
            {mem[NIDX+5].res, mem[5].res}, 8'h0F);

      // R2/R6: line with no matching key writes nothing
      put(0, 9, '{key: K1, usr: 1'b1, tmp: 1'b0, res: 4'h3});
      put(1, 9, '{key: K1, usr: 1'b0, tmp: 1'b1, res: 4'h5});
      run_cmd(2'd0, {K0, 10'd9, 4'h0}, 1'b0, 1'b0, "R2");

      // R3: page command in user mode
      put(1, 1023, '{key: K1, usr: 1'b1, tmp: 1'b0, res: 4'h8});
      run_cmd(2'd1, {K1, 10'd77, 4'h4}, 1'b1, 1'b0, "R3");
      check(mem[2*NIDX-1].res == 0, "R3", "last index cleared", mem[2*NIDX-1].res, 0);

      // R5: temporary data, supervisor
      fill(32'hCAFE_0001);
      run_cmd(2'd3, 32'h0, 1'b0, 1'b0, "R5");

      // R4 + R8: whole cache in user mode, refused command offered mid-walk
      fill(32'h0BAD_F00D);
      run_cmd(2'd2, 32'h0, 1'b1, 1'b1, "R4");

      // R3: page in supervisor mode
      fill(32'h7777_1111);
      run_cmd(2'd1, {K0, 14'h0}, 1'b0, 1'b0, "R3");

      // R4: whole cache, supervisor clears everything
      fill(32'h2468_ACE0);
      run_cmd(2'd2, 32'h0, 1'b0, 1'b0, "R4");
      begin
         int left;
         left = 0;
         for (int i = 0; i < 2*NIDX; i++) if (mem[i].res != 0) left++;
         check(left == 0, "R4", "entries still resident", left, 0);
      end

      $display("%0d/%0d checks passed", chk - bad, chk);
      $finish;
   end
endmodule